// File: doc/BRIEF.md
# Immediate-Operand Execute Unit

This block is the arithmetic and logic stage of a 32-bit load-store processor pipeline. It has no clock. A decoded operation select, two register operands, a 16-bit instruction constant and a 5-bit shift field go in. A 32-bit result and a misaligned-access flag come out in the same cycle.

Each immediate instruction extends its constant in its own way. Signed add, the compares and address generation sign-extend the constant. Unsigned add and the bitwise immediates zero-extend it. Load-upper places the constant in the high half of the result. For memory instructions the result is the effective address. Word accesses are checked for alignment on that address. Byte accesses are never checked. The surrounding pipeline decodes the instruction, reads the register file, consumes the result and drives memory.

Top module: `imm_exec_unit`

## Requirements
- R1: The operation select `op_sel` uses these codes, and every other code (29, 30, 31) returns zero with no flag:
  - 0: idle, result zero
  - 1 and 2: register add (signed and unsigned forms)
  - 3 and 4: register subtract `rs - rt` (signed and unsigned forms)
  - 5, 6, 7, 8: AND, OR, XOR, NOR
  - 9 and 10: signed and unsigned less-than
  - 11, 12, 13: left logical, right logical and right arithmetic shift by `shamt`
  - 14, 15, 16: the same three shifts by a register amount
  - 17: add-immediate
  - 18: unsigned add-immediate
  - 19, 20, 21: AND-, OR- and XOR-immediate
  - 22: load-upper
  - 23 and 24: signed and unsigned less-than-immediate
  - 25: word load
  - 26: word store
  - 27: byte load
  - 28: byte store
- R2: Add-immediate sign-extends the 16-bit constant, so 0xFFFD adds -3.
- R3: Unsigned add-immediate and the AND-, OR- and XOR-immediates zero-extend the constant (0xFF12 acts as 0x0000FF12).
- R4: Load-upper returns the constant in bits 31:16 and zeros in bits 15:0.
- R5: The less-than operations return 1 when `rs_val` is below the second operand and 0 otherwise, with bits 31:1 always zero. The immediate forms compare against the sign-extended constant. The unsigned forms compare as unsigned numbers.
- R6: AND, OR, XOR and NOR combine `rs_val` and `rt_val` over all 32 bits.
- R7: Shifts act on `rt_val`. The constant forms shift by `shamt`. The register forms shift by bits 4:0 of `rs_val` and ignore its upper bits. Arithmetic right shift replicates bit 31.
- R8: For loads and stores, the result is `rs_val` plus the sign-extended constant.
- R9: `misaligned` is 1 only for a word load or word store whose effective address has nonzero bits 1:0. It is 0 for byte accesses and for every other operation.
- R10: All add and subtract forms wrap modulo 2^32 and raise no error indication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 5 | Decoded operation code (R1) |
| rs_val | input | 32 | First register operand / base address / variable shift amount |
| rt_val | input | 32 | Second register operand / shift source |
| imm | input | 16 | Instruction constant |
| shamt | input | 5 | Constant shift amount |
| result | output | 32 | Operation result or effective address |
| misaligned | output | 1 | Word access with unaligned address |

## Verification
The bench builds the unit with its default 32-bit datapath and 16-bit constant. These defaults make the extension boundaries reachable directly: 0x7FFF against 0x8000 and above, and 0xFFFF in both extension modes. The adder wraps at 0x7FFFFFFF and 0xFFFFFFFF. Shift amounts go up to 31, with upper bits set in the register amount. Word and byte addresses are tried at each low-bit offset. The same 0xFFFF constant is driven under signed and unsigned compares, which separates the extension rule from the comparison rule.

// File: rtl/imm_exec_unit.sv
module imm_exec_unit #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [4:0]        op_sel,
  input  logic [DATA_W-1:0] rs_val,
  input  logic [DATA_W-1:0] rt_val,
  input  logic [IMM_W-1:0]  imm,
  input  logic [4:0]        shamt,
  output logic [DATA_W-1:0] result,
  output logic              misaligned
);
  localparam int SH_W   = $clog2(DATA_W);
  localparam int ALIGN  = $clog2(DATA_W / 8);
  localparam int EXT_W  = DATA_W - IMM_W;

  localparam logic [4:0] OP_IDLE = 5'd0,  OP_ADD  = 5'd1,  OP_ADDU = 5'd2,
                         OP_SUB  = 5'd3,  OP_SUBU = 5'd4,  OP_AND  = 5'd5,
                         OP_OR   = 5'd6,  OP_XOR  = 5'd7,  OP_NOR  = 5'd8,
                         OP_SLT  = 5'd9,  OP_SLTU = 5'd10, OP_SLL  = 5'd11,
                         OP_SRL  = 5'd12, OP_SRA  = 5'd13, OP_SLLV = 5'd14,
                         OP_SRLV = 5'd15, OP_SRAV = 5'd16, OP_ADDI = 5'd17,
                         OP_ADDIU= 5'd18, OP_ANDI = 5'd19, OP_ORI  = 5'd20,
                         OP_XORI = 5'd21, OP_LUI  = 5'd22, OP_SLTI = 5'd23,
                         OP_SLTIU= 5'd24, OP_LW   = 5'd25, OP_SW   = 5'd26,
                         OP_LB   = 5'd27, OP_SB   = 5'd28;

  logic [DATA_W-1:0] imm_sx, imm_zx, imm_hi;
  assign imm_sx = {{EXT_W{imm[IMM_W-1]}}, imm};
  assign imm_zx = {{EXT_W{1'b0}}, imm};
  assign imm_hi = {imm, {EXT_W{1'b0}}};

  logic use_imm, imm_signed;
  always_comb begin
    use_imm    = 1'b0;
    imm_signed = 1'b0;
    unique case (op_sel)
      OP_ADDI, OP_SLTI, OP_SLTIU, OP_LW, OP_SW, OP_LB, OP_SB: begin
        use_imm = 1'b1; imm_signed = 1'b1;
      end
      OP_ADDIU, OP_ANDI, OP_ORI, OP_XORI: use_imm = 1'b1;
      default: ;
    endcase
  end

  logic [DATA_W-1:0] opnd_b;
  assign opnd_b = !use_imm ? rt_val : (imm_signed ? imm_sx : imm_zx);

  logic [DATA_W-1:0] sum, diff;
  assign sum  = rs_val + opnd_b;
  assign diff = rs_val - opnd_b;

  logic lt_s, lt_u;
  assign lt_s = $signed(rs_val) < $signed(opnd_b);
  assign lt_u = rs_val < opnd_b;

  logic [SH_W-1:0] sh_amt;
  logic            sh_var;
  assign sh_var = (op_sel == OP_SLLV) || (op_sel == OP_SRLV) || (op_sel == OP_SRAV);
  assign sh_amt = sh_var ? rs_val[SH_W-1:0] : SH_W'(shamt);

  logic [DATA_W-1:0] shl, shr, sha;
  assign shl = rt_val << sh_amt;
  assign shr = rt_val >> sh_amt;
  assign sha = DATA_W'($signed(rt_val) >>> sh_amt);

  always_comb begin
    result = '0;
    unique case (op_sel)
      OP_ADD, OP_ADDU, OP_ADDI, OP_ADDIU,
      OP_LW, OP_SW, OP_LB, OP_SB:           result = sum;
      OP_SUB, OP_SUBU:                      result = diff;
      OP_AND, OP_ANDI:                      result = rs_val & opnd_b;
      OP_OR,  OP_ORI:                       result = rs_val | opnd_b;
      OP_XOR, OP_XORI:                      result = rs_val ^ opnd_b;
      OP_NOR:                               result = ~(rs_val | opnd_b);
      OP_SLT, OP_SLTI:                      result = DATA_W'(lt_s);
      OP_SLTU, OP_SLTIU:                    result = DATA_W'(lt_u);
      OP_SLL, OP_SLLV:                      result = shl;
      OP_SRL, OP_SRLV:                      result = shr;
      OP_SRA, OP_SRAV:                      result = sha;
      OP_LUI:                               result = imm_hi;
      default:                              result = '0;
    endcase
  end

  assign misaligned = ((op_sel == OP_LW) || (op_sel == OP_SW)) && (sum[ALIGN-1:0] != '0);
endmodule

module imm_exec_unit_chk #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input logic [4:0]        op_sel,
  input logic [DATA_W-1:0] rs_val,
  input logic [DATA_W-1:0] rt_val,
  input logic [IMM_W-1:0]  imm,
  input logic [4:0]        shamt,
  input logic [DATA_W-1:0] result,
  input logic              misaligned
);
  always_comb begin
    if (op_sel >= 5'd29)
      a_r1_unused_zero: assert (result == '0 && !misaligned);
    if (op_sel == 5'd22)
      a_r4_lui_low_clear: assert (result[DATA_W-IMM_W-1:0] == '0 && result[DATA_W-1:DATA_W-IMM_W] == imm);
    if (op_sel == 5'd9 || op_sel == 5'd10 || op_sel == 5'd23 || op_sel == 5'd24)
      a_r5_compare_bool: assert (result[DATA_W-1:1] == '0);
    if (op_sel == 5'd19)
      a_r3_andi_high_clear: assert (result[DATA_W-1:IMM_W] == '0);
    if (op_sel != 5'd25 && op_sel != 5'd26)
      a_r9_flag_word_only: assert (!misaligned);
    if (op_sel == 5'd1 || op_sel == 5'd2)
      a_r10_add_wraps: assert (result == rs_val + rt_val);
  end
endmodule

bind imm_exec_unit imm_exec_unit_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_chk (
  .op_sel(op_sel), .rs_val(rs_val), .rt_val(rt_val), .imm(imm),
  .shamt(shamt), .result(result), .misaligned(misaligned)
);

// File: tb/imm_exec_unit_tb.sv
module imm_exec_unit_tb;
  logic        clk = 1'b0;
  logic [4:0]  op_sel;
  logic [31:0] rs_val, rt_val;
  logic [15:0] imm;
  logic [4:0]  shamt;
  logic [31:0] result;
  logic        misaligned;
  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  imm_exec_unit u_dut (
    .op_sel(op_sel), .rs_val(rs_val), .rt_val(rt_val), .imm(imm),
    .shamt(shamt), .result(result), .misaligned(misaligned)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000 && !done) begin
      failures = failures + 1;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic drive(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [15:0] k, input logic [4:0] sa);
    @(negedge clk);
    op_sel = op; rs_val = a; rt_val = b; imm = k; shamt = sa;
    #1;
  endtask

  task automatic expect_res(input string req, input logic [31:0] exp_r, input logic exp_f);
    checks = checks + 1;
    if (result !== exp_r || misaligned !== exp_f) begin
      failures = failures + 1;
      $display("FAIL %s: actual=%h/%b expected=%h/%b", req, result, misaligned, exp_r, exp_f);
    end
  endtask

  task automatic t_r1_codes;
    drive(5'd0, 32'hDEADBEEF, 32'h1234, 16'hFFFF, 5'd3); expect_res("R1 idle", 32'h0, 1'b0);
    drive(5'd30, 32'hDEADBEEF, 32'h1234, 16'hFFFF, 5'd3); expect_res("R1 unused30", 32'h0, 1'b0);
    drive(5'd31, 32'h1001, 32'h1, 16'h0, 5'd0); expect_res("R1 unused31", 32'h0, 1'b0);
  endtask

  task automatic t_r2_addi;
    drive(5'd17, 32'd100, 32'h0, 16'hFFFD, 5'd0); expect_res("R2 addi -3", 32'd97, 1'b0);
    drive(5'd17, 32'd5, 32'h0, 16'h7FFF, 5'd0); expect_res("R2 addi 7fff", 32'h8004, 1'b0);
  endtask

  task automatic t_r3_zext;
    drive(5'd18, 32'd1, 32'h0, 16'hFFFF, 5'd0); expect_res("R3 addiu", 32'h10000, 1'b0);
    drive(5'd21, 32'h12345678, 32'h0, 16'hFF12, 5'd0); expect_res("R3 xori", 32'h1234A96A, 1'b0);
    drive(5'd19, 32'hFFFFFFFF, 32'h0, 16'h8723, 5'd0); expect_res("R3 andi", 32'h00008723, 1'b0);
  endtask

  task automatic t_r4_lui;
    drive(5'd22, 32'hFFFFFFFF, 32'hFFFFFFFF, 16'h5678, 5'd0); expect_res("R4 lui", 32'h56780000, 1'b0);
    drive(5'd20, 32'h56780000, 32'h0, 16'hABCD, 5'd0); expect_res("R4 lui+ori", 32'h5678ABCD, 1'b0);
  endtask

  task automatic t_r5_compare;
    drive(5'd9, 32'hFFFFFFFF, 32'd1, 16'h0, 5'd0); expect_res("R5 slt", 32'd1, 1'b0);
    drive(5'd10, 32'hFFFFFFFF, 32'd1, 16'h0, 5'd0); expect_res("R5 sltu", 32'd0, 1'b0);
    drive(5'd9, 32'd7, 32'd7, 16'h0, 5'd0); expect_res("R5 slt equal", 32'd0, 1'b0);
    drive(5'd23, 32'hFFFFFFFB, 32'h0, 16'hFFFE, 5'd0); expect_res("R5 slti", 32'd1, 1'b0);
    drive(5'd24, 32'd5, 32'h0, 16'hFFFF, 5'd0); expect_res("R5 sltiu", 32'd1, 1'b0);
    drive(5'd23, 32'd5, 32'h0, 16'hFFFF, 5'd0); expect_res("R5 slti neg", 32'd0, 1'b0);
  endtask

  task automatic t_r6_logic;
    drive(5'd5, 32'hF0F01234, 32'h0FF0FFFF, 16'h0, 5'd0); expect_res("R6 and", 32'h00F01234, 1'b0);
    drive(5'd6, 32'hF0F01234, 32'h0FF0FFFF, 16'h0, 5'd0); expect_res("R6 or", 32'hFFF0FFFF, 1'b0);
    drive(5'd7, 32'hF0F01234, 32'h0FF0FFFF, 16'h0, 5'd0); expect_res("R6 xor", 32'hFF00EDCB, 1'b0);
    drive(5'd8, 32'hF0F01234, 32'h0FF0FFFF, 16'h0, 5'd0); expect_res("R6 nor", 32'h000F0000, 1'b0);
  endtask

  task automatic t_r7_shift;
    drive(5'd11, 32'h0, 32'd1, 16'h0, 5'd31); expect_res("R7 sll", 32'h80000000, 1'b0);
    drive(5'd12, 32'h0, 32'h80000000, 16'h0, 5'd4); expect_res("R7 srl", 32'h08000000, 1'b0);
    drive(5'd13, 32'h0, 32'h80000000, 16'h0, 5'd4); expect_res("R7 sra", 32'hF8000000, 1'b0);
    drive(5'd14, 32'hFFFFFFE3, 32'd1, 16'h0, 5'd0); expect_res("R7 sllv low5", 32'h8, 1'b0);
    drive(5'd15, 32'h00000044, 32'h80000000, 16'h0, 5'd9); expect_res("R7 srlv", 32'h08000000, 1'b0);
    drive(5'd16, 32'd4, 32'h80000000, 16'h0, 5'd0); expect_res("R7 srav", 32'hF8000000, 1'b0);
  endtask

  task automatic t_r8_r9_addr;
    drive(5'd25, 32'h1000, 32'h0, 16'hFFFC, 5'd0); expect_res("R8 lw neg", 32'h0FFC, 1'b0);
    drive(5'd26, 32'h1008, 32'h0, 16'h0004, 5'd0); expect_res("R8 sw", 32'h100C, 1'b0);
    drive(5'd25, 32'h1001, 32'h0, 16'h0, 5'd0); expect_res("R9 lw unaligned", 32'h1001, 1'b1);
    drive(5'd26, 32'h1000, 32'h0, 16'h0002, 5'd0); expect_res("R9 sw unaligned", 32'h1002, 1'b1);
    drive(5'd27, 32'h1000, 32'h0, 16'h0003, 5'd0); expect_res("R9 lb odd", 32'h1003, 1'b0);
    drive(5'd28, 32'h1001, 32'h0, 16'hFFFF, 5'd0); expect_res("R9 sb", 32'h1000, 1'b0);
    drive(5'd18, 32'h1001, 32'h0, 16'h0, 5'd0); expect_res("R9 addiu no flag", 32'h1001, 1'b0);
  endtask

  task automatic t_r10_wrap;
    drive(5'd1, 32'h7FFFFFFF, 32'd1, 16'h0, 5'd0); expect_res("R10 add wrap", 32'h80000000, 1'b0);
    drive(5'd2, 32'hFFFFFFFF, 32'd2, 16'h0, 5'd0); expect_res("R10 addu wrap", 32'd1, 1'b0);
    drive(5'd3, 32'd0, 32'd1, 16'h0, 5'd0); expect_res("R10 sub", 32'hFFFFFFFF, 1'b0);
    drive(5'd4, 32'd10, 32'd3, 16'h0, 5'd0); expect_res("R10 subu", 32'd7, 1'b0);
    drive(5'd17, 32'hFFFFFFFF, 32'h0, 16'h0001, 5'd0); expect_res("R10 addi wrap", 32'd0, 1'b0);
  endtask

  initial begin
    op_sel = '0; rs_val = '0; rt_val = '0; imm = '0; shamt = '0;
    t_r1_codes;
    t_r2_addi;
    t_r3_zext;
    t_r4_lui;
    t_r5_compare;
    t_r6_logic;
    t_r7_shift;
    t_r8_r9_addr;
    t_r10_wrap;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule